// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block produces the bit clock for one serial channel. It loads a 16-bit time constant into a down-counter, counts the counter to zero, then reloads it and inverts a square-wave output. One output half-period therefore lasts TC+2 counting ticks, and the output frequency is the tick rate divided by 2·(TC+2). Each pass through zero also sets a sticky zero-count status flag. This flag can raise an interrupt when its enable is set.

The time constant is written one byte at a time. A new value is held in the byte registers and is picked up only at the next reload, so the half-period in progress is never cut short or stretched. Counting ticks come from one of two sources. The first is the processor clock, which gives one tick per cycle. The second is an external strobe, which gives one tick per cycle in which the strobe is high. Both sources are sampled in the single system clock domain. Counting happens only while the enable input is high.

The controller has two states. BG_HALT is the state with counting stopped. BG_COUNT is the state with counting active. The transitions are:
- ARM: BG_HALT to BG_COUNT when the enable is seen high. The counter is preloaded with TC+1 in that cycle and no tick is used.
- STEP: BG_COUNT to BG_COUNT on a tick with a non-zero count. The count is decremented.
- WRAP: BG_COUNT to BG_COUNT on a tick at zero. The counter reloads, the output inverts and the zero-count flag is set.
- PARK: BG_COUNT to BG_HALT when the enable drops. The count and the output hold their values.

Top module: `baud_gen`

## Requirements
- R1: After reset `bclk_out`, `zc_status` and `zc_irq` are 0, and the time constant is 0.
- R2: With the processor clock selected and the enable held high, `bclk_out` inverts every TC+2 cycles. Its full period is 2·(TC+2) cycles.
- R3: The time constant is 16 bits. `tc_we[0]` writes `tc_wdata` into bits 7:0 and `tc_we[1]` writes it into bits 15:8.
- R4: A time-constant write made during a half-period does not change that half-period. The new value sets the length of the half-period after the next reload.
- R5: While `count_en` is low, `bclk_out` holds its value and the count is frozen. When `count_en` is next seen high, the counter is preloaded with TC+1 in that cycle, and counting starts in the following cycle.
- R6: With `src_pclk` = 1 every cycle is a tick. With `src_pclk` = 0 only cycles in which `ext_tick` is high are ticks, and other cycles leave the output unchanged.
- R7: Every reload sets `zc_status`. The flag stays set until a cycle with `zc_ack` high clears it. If a reload and `zc_ack` fall in the same cycle, the flag is set.
- R8: `zc_irq` is high exactly when `zc_status` is high and `zc_ie` is high.
- R9: With TC = 0 the output inverts every 2 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_we | input | 2 | Byte write enables for the time constant (bit 0 = low byte) |
| tc_wdata | input | 8 | Byte written into the time constant |
| count_en | input | 1 | Counting enable |
| src_pclk | input | 1 | 1: tick on every cycle; 0: tick on the external strobe |
| ext_tick | input | 1 | External clock strobe, synchronous to clk |
| zc_ie | input | 1 | Zero-count interrupt enable |
| zc_ack | input | 1 | Clears the zero-count flag |
| bclk_out | output | 1 | Square-wave bit clock |
| zc_status | output | 1 | Sticky zero-count flag |
| zc_irq | output | 1 | Zero-count interrupt request |

## Verification
The bound assertions check several cycle-local rules on every clock:
- The output is frozen while counting is disabled or while the external source has no strobe.
- Every output edge comes with a set zero-count flag.
- The flag stays set until it is acknowledged.
- The interrupt follows the flag and its mask.

Other behaviours depend on the whole run of ticks and writes, and only the bench's scenarios show them. These are the exact half-period length for a given time constant (small, zero and multi-byte), the deferral of a time-constant write to the next reload, the preload on re-enable, and the spacing under a sparse external strobe.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
    typedef enum logic [0:0] {
        BG_HALT  = 1'b0,
        BG_COUNT = 1'b1
    } bg_state_e;
endpackage

// File: rtl/bgen_tc_regs.sv
module bgen_tc_regs #(
    parameter int TC_W   = 16,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TC_W/BYTE_W-1:0]   byte_we,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [TC_W-1:0]          tc
);
    localparam int NBYTES = TC_W / BYTE_W;

    // one byte lane per write enable; lane 0 is the least significant
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tc[b*BYTE_W +: BYTE_W] <= '0;
            end else if (byte_we[b]) begin
                tc[b*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end
endmodule

// File: rtl/bgen_tick_sel.sv
module bgen_tick_sel (
    input  logic enable,
    input  logic src_pclk,
    input  logic ext_tick,
    output logic tick
);
    always_comb begin
        tick = enable & (src_pclk | ext_tick);
    end
endmodule

// File: rtl/bgen_counter.sv
module bgen_counter
    import bgen_pkg::*;
#(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            tick,
    input  logic [TC_W-1:0] tc,
    output logic            wrap,
    output logic            bclk
);
    localparam int CNT_W = TC_W + 1;

    bg_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] reload_val;
    logic             bclk_q;

    assign reload_val = {1'b0, tc} + CNT_W'(1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BG_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and counter value
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wrap    = 1'b0;
        unique case (state_q)
            BG_HALT: begin
                if (enable) begin
                    state_d = BG_COUNT;        // ARM
                    cnt_d   = reload_val;
                end
            end
            BG_COUNT: begin
                if (!enable) begin
                    state_d = BG_HALT;         // PARK
                end else if (tick) begin
                    if (cnt_q == '0) begin
                        cnt_d = reload_val;    // WRAP
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);  // STEP
                    end
                end
            end
            default: state_d = BG_HALT;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (wrap) begin
                bclk_q <= ~bclk_q;
            end
        end
    end

    assign bclk = bclk_q;
endmodule

// File: rtl/bgen_status.sv
module bgen_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ack,
    input  logic ie,
    output logic status,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (wrap) begin
            status <= 1'b1;
        end else if (ack) begin
            status <= 1'b0;
        end
    end

    assign irq = status & ie;
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
    parameter int TC_W   = 16,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TC_W/BYTE_W-1:0]  tc_we,
    input  logic [BYTE_W-1:0]       tc_wdata,
    input  logic                    count_en,
    input  logic                    src_pclk,
    input  logic                    ext_tick,
    input  logic                    zc_ie,
    input  logic                    zc_ack,
    output logic                    bclk_out,
    output logic                    zc_status,
    output logic                    zc_irq
);
    logic [TC_W-1:0] tc;
    logic            tick;
    logic            wrap;

    bgen_tc_regs #(.TC_W(TC_W), .BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (tc_we),
        .wdata   (tc_wdata),
        .tc      (tc)
    );

    bgen_tick_sel u_sel (
        .enable   (count_en),
        .src_pclk (src_pclk),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    bgen_counter #(.TC_W(TC_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (count_en),
        .tick   (tick),
        .tc     (tc),
        .wrap   (wrap),
        .bclk   (bclk_out)
    );

    bgen_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .ack    (zc_ack),
        .ie     (zc_ie),
        .status (zc_status),
        .irq    (zc_irq)
    );
endmodule

// File: rtl/bgen_chk.sv
module bgen_chk (
    input logic clk,
    input logic rst_n,
    input logic count_en,
    input logic src_pclk,
    input logic ext_tick,
    input logic zc_ie,
    input logic zc_ack,
    input logic bclk_out,
    input logic zc_status,
    input logic zc_irq
);
    // R5
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> $stable(bclk_out));

    // R6
    ext_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_pclk && !ext_tick) |=> $stable(bclk_out));

    // R7
    edge_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bclk_out) |-> zc_status);

    // R7
    zc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_status && !zc_ack) |=> zc_status);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zc_ie |-> !zc_irq);

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zc_irq |-> zc_status);
endmodule

bind baud_gen bgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (count_en),
    .src_pclk  (src_pclk),
    .ext_tick  (ext_tick),
    .zc_ie     (zc_ie),
    .zc_ack    (zc_ack),
    .bclk_out  (bclk_out),
    .zc_status (zc_status),
    .zc_irq    (zc_irq)
);

// File: tb/baud_gen_test.sv
`timescale 1ns/1ps
module baud_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tc_we = 2'b00;
    logic [7:0] tc_wdata = 8'h00;
    logic       count_en = 1'b0;
    logic       src_pclk = 1'b1;
    logic       ext_tick = 1'b0;
    logic       zc_ie = 1'b0;
    logic       zc_ack = 1'b0;
    logic       bclk_out, zc_status, zc_irq;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit ext_run = 1'b0;
    int ext_cnt = 0;

    // reference model state
    int m_tc = 0;
    int m_cnt = 0;
    bit m_run = 0;
    bit m_out = 0;
    bit m_st = 0;

    always #5 clk = ~clk;

    baud_gen uut (
        .clk(clk), .rst_n(rst_n), .tc_we(tc_we), .tc_wdata(tc_wdata),
        .count_en(count_en), .src_pclk(src_pclk), .ext_tick(ext_tick),
        .zc_ie(zc_ie), .zc_ack(zc_ack),
        .bclk_out(bclk_out), .zc_status(zc_status), .zc_irq(zc_irq)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        bit tk, ev;
        ev = 0;
        if (!rst_n) begin
            m_tc = 0; m_cnt = 0; m_run = 0; m_out = 0; m_st = 0;
        end else begin
            tk = count_en && (src_pclk || ext_tick);
            if (!count_en) m_run = 0;
            else if (!m_run) begin m_run = 1; m_cnt = m_tc + 1; end
            else if (tk) begin
                if (m_cnt == 0) begin m_cnt = m_tc + 1; m_out = !m_out; ev = 1; end
                else m_cnt = m_cnt - 1;
            end
            if (ev) m_st = 1;
            else if (zc_ack) m_st = 0;
            if (tc_we[0]) m_tc = (m_tc & 32'hFF00) | tc_wdata;
            if (tc_we[1]) m_tc = (m_tc & 32'h00FF) | (int'(tc_wdata) << 8);
        end
    end

    // external strobe generator: high on every third cycle
    always @(posedge clk) begin
        #1;
        if (ext_run) begin
            ext_cnt++;
            ext_tick = (ext_cnt % 3 == 0);
        end else begin
            ext_cnt = 0;
            ext_tick = 1'b0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (bclk_out !== m_out) begin
                fails++;
                $display("FAIL R2 bclk_out actual=%0b expected=%0b t=%0t", bclk_out, m_out, $time);
            end
            if (zc_status !== m_st) begin
                fails++;
                $display("FAIL R7 zc_status actual=%0b expected=%0b t=%0t", zc_status, m_st, $time);
            end
            if (zc_irq !== (m_st && zc_ie)) begin
                fails++;
                $display("FAIL R8 zc_irq actual=%0b expected=%0b t=%0t", zc_irq, m_st && zc_ie, $time);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_tc(input int v);
        @(posedge clk); #1;
        tc_we = 2'b01; tc_wdata = v[7:0];
        @(posedge clk); #1;
        tc_we = 2'b10; tc_wdata = v[15:8];
        @(posedge clk); #1;
        tc_we = 2'b00;
    endtask

    // waits for an output edge, then counts cycles to the next one
    task automatic measure(input int exp, input string req);
        logic prev;
        int n;
        @(negedge clk);
        prev = bclk_out;
        while (bclk_out === prev) @(negedge clk);
        prev = bclk_out;
        n = 0;
        while (bclk_out === prev && n < 2000) begin @(negedge clk); n++; end
        check(n == exp, req, n, exp);
        @(posedge clk); #1;
    endtask

    initial begin
        logic held;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(bclk_out === 1'b0, "R1 bclk_out", bclk_out, 0);
        check(zc_status === 1'b0, "R1 zc_status", zc_status, 0);
        check(zc_irq === 1'b0, "R1 zc_irq", zc_irq, 0);
        @(posedge clk); #1;

        // R2: TC=3 on processor clock, half-period 5
        zc_ie = 1'b1;
        write_tc(3);
        count_en = 1'b1;
        measure(5, "R2 half-period TC=3");
        measure(5, "R2 half-period TC=3 repeat");
        @(negedge clk);
        check(zc_status === 1'b1, "R7 flag after reload", zc_status, 1);
        check(zc_irq === 1'b1, "R8 irq with enable", zc_irq, 1);

        // R8: mask
        @(posedge clk); #1; zc_ie = 1'b0;
        @(negedge clk);
        check(zc_irq === 1'b0, "R8 irq masked", zc_irq, 0);
        @(posedge clk); #1; zc_ie = 1'b1;

        // R9: TC=0
        write_tc(0);
        measure(2, "R9 half-period TC=0");
        measure(2, "R9 half-period TC=0 repeat");

        // R3: multi-byte value 0x0102 -> half-period 260
        write_tc(16'h0102);
        measure(260, "R3 high byte half-period");

        // R4: write during a half-period is deferred
        write_tc(10);
        measure(12, "R4 settle TC=10");
        @(negedge clk);
        while (bclk_out === held || 1'b0) begin held = bclk_out; break; end
        held = bclk_out;
        while (bclk_out === held) @(negedge clk);
        write_tc(1);
        measure(3, "R4 new value after reload");

        // R5: disable freezes output, flag clears with ack
        @(posedge clk); #1; count_en = 1'b0;
        @(negedge clk);
        held = bclk_out;
        @(posedge clk); #1; zc_ack = 1'b1;
        @(posedge clk); #1; zc_ack = 1'b0;
        step(20);
        @(negedge clk);
        check(bclk_out === held, "R5 output held when disabled", bclk_out, held);
        check(zc_status === 1'b0, "R7 ack clears flag", zc_status, 0);
        check(zc_irq === 1'b0, "R8 irq follows cleared flag", zc_irq, 0);
        @(posedge clk); #1;
        count_en = 1'b1;
        measure(3, "R5 restart period");

        // R7: ack held constantly, reload still sets the flag
        zc_ack = 1'b1;
        measure(3, "R7 period with ack held");
        zc_ack = 1'b0;

        // R6: external strobe every 3rd cycle, TC=1 -> 9 cycles
        src_pclk = 1'b0;
        ext_run = 1'b1;
        measure(9, "R6 external strobe half-period");
        measure(9, "R6 external strobe repeat");
        ext_run = 1'b0;
        step(2);
        @(negedge clk);
        held = bclk_out;
        step(15);
        @(negedge clk);
        check(bclk_out === held, "R6 no strobe no edge", bclk_out, held);

        step(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule